// File: doc/BRIEF.md
# Pulse-Pause Reader Frame Transmitter

This block sends one command frame from a reader to a card by keying a carrier-enable line. Each bit is a short carrier-off gap followed by a carrier-on stretch, and the length of that stretch carries the bit value. Before a bit is encoded, it is XORed with one bit of an external keystream. When a pulse on `start` is accepted, the block waits a fixed gap, sends the frame starting at bit 0, and ends with a terminating carrier-off pause. It then returns the carrier to on and pulses `done`.

All timing is counted in pulses of `tick`, a single-cycle strobe at 1.5 MHz. The schedule is kept as one running timestamp from the moment `start` is accepted. Each phase boundary is the previous boundary plus a fixed interval, so the length of one phase never adds error to later phases. The keystream source and any CRC logic sit outside this block. The block samples `key_bit` and asks for the next keystream bit with `key_adv`.

Top module: `pp_frame_tx`

## Requirements
- R1: While reset is held, and after it, until a frame is accepted, `carrier` is 1 and `busy`, `done` and `key_adv` are 0.
- R2: A `start` sampled while idle is accepted, and `busy` is 1 in the following cycle. A `start` sampled while `busy` is 1 is ignored: the frame in flight keeps its data, length and timing.
- R3: The first carrier-off edge of a frame falls exactly 330 ticks after the clock edge that accepted `start`.
- R4: Each bit is 30 ticks of carrier off followed by carrier on. The carrier-on time is 60 ticks when the encoded bit is 0 and 120 ticks when it is 1, so a bit lasts 90 or 150 ticks.
- R5: Bit i of the frame (i = 0 first) is encoded as `frame_data[i] ^ key_bit`. `key_bit` is sampled on the tick where that bit's pause begins. `key_adv` then pulses for one cycle in the next clock cycle, and it pulses exactly once per bit sent.
- R6: After the last bit, the carrier is off for 30 ticks. On the tick that ends this pause, `carrier` returns to 1, `busy` falls and `done` pulses for exactly one cycle.
- R7: A length of 0 produces only the 330-tick gap and the 30-tick terminating pause, with no `key_adv`.
- R8: A `frame_len` greater than 32 is treated as 32.
- R9: `carrier` changes only after a clock edge at which `tick` was 1. Phase durations count ticks and do not depend on how many clock cycles lie between ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick | input | 1 | Single-cycle timebase strobe, 1.5 MHz |
| start | input | 1 | Request to send a frame; ignored while busy |
| frame_data | input | 32 | Frame bits, bit 0 sent first; latched on acceptance |
| frame_len | input | 6 | Number of bits to send, 0 to 32; larger values are clamped to 32 |
| key_bit | input | 1 | Current keystream bit |
| carrier | output | 1 | Carrier enable, 1 = carrier on |
| key_adv | output | 1 | One-cycle request to advance the keystream |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The checker watches the cycle-level rules on every clock. These are: the carrier stays on while idle, carrier edges occur only after a tick, `done` and `key_adv` are single-cycle pulses, `key_adv` occurs only during a pause, the end of a frame coincides with `done`, and an accepted start raises `busy`. The exact tick counts of the gap, the pauses and the bit stretches can only be shown by the bench's scenarios. The same holds for the XOR with the keystream, length clamping, the zero-length frame and the ignored mid-frame start. The bench records the tick count at every carrier edge and compares it with a schedule it computes itself. It does this over several tick spacings.

// File: rtl/pp_tx_pkg.sv
package pp_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_PAUSE,
    ST_HOLD,
    ST_TAIL
  } tx_state_e;

  // Longest schedule in ticks for a frame of nbits one-bits.
  function automatic int unsigned worst_ticks(int unsigned gap, int unsigned nbits,
                                              int unsigned one_t, int unsigned pause);
    return gap + nbits * one_t + pause;
  endfunction

endpackage

// File: rtl/pp_tx_sched.sv
// Running timestamp plus absolute deadline; phase ends when the timestamp
// reaches the deadline, deadline then advanced by the next interval.
module pp_tx_sched #(
  parameter int unsigned TW  = 13,
  parameter int unsigned GAP = 330
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic          step,
  input  logic [TW-1:0] interval,
  output logic          hit
);

  logic [TW-1:0] now_q, now_d;
  logic [TW-1:0] due_q, due_d;
  logic          en;

  assign hit = tick && ((now_q + TW'(1)) == due_q);
  assign en  = load | tick | step;

  always_comb begin
    now_d = now_q;
    due_d = due_q;
    if (load) begin
      now_d = '0;
      due_d = TW'(GAP);
    end else begin
      if (tick) now_d = now_q + TW'(1);
      if (step) due_d = due_q + interval;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q <= '0;
      due_q <= '0;
    end else if (en) begin
      now_q <= now_d;
      due_q <= due_d;
    end
  end

endmodule

// File: rtl/pp_tx_shifter.sv
// Holds the latched frame and the count of bits still to send.
module pp_tx_shifter #(
  parameter int unsigned MAXB = 32,
  parameter int unsigned LW   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            shift,
  input  logic [MAXB-1:0] frame_data,
  input  logic [LW-1:0]   frame_len,
  output logic            cur_bit,
  output logic            empty
);

  logic [MAXB-1:0] data_q, data_d;
  logic [LW-1:0]   left_q, left_d;
  logic [LW-1:0]   len_eff;

  assign len_eff = (frame_len > LW'(MAXB)) ? LW'(MAXB) : frame_len;
  assign cur_bit = data_q[0];
  assign empty   = (left_q == '0);

  always_comb begin
    data_d = data_q;
    left_d = left_q;
    if (load) begin
      data_d = frame_data;
      left_d = len_eff;
    end else if (shift) begin
      data_d = data_q >> 1;
      left_d = left_q - LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      left_q <= '0;
    end else if (load | shift) begin
      data_q <= data_d;
      left_q <= left_d;
    end
  end

endmodule

// File: rtl/pp_tx_ctrl.sv
module pp_tx_ctrl
  import pp_tx_pkg::*;
#(
  parameter int unsigned TW      = 13,
  parameter int unsigned PAUSE_T = 30,
  parameter int unsigned ZERO_T  = 90,
  parameter int unsigned ONE_T   = 150
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          hit,
  input  logic          cur_bit,
  input  logic          key_bit,
  input  logic          empty,
  output logic          load,
  output logic          shift,
  output logic          step,
  output logic [TW-1:0] interval,
  output logic          carrier,
  output logic          busy,
  output logic          done,
  output logic          key_adv
);

  localparam logic [TW-1:0] PauseIv = TW'(PAUSE_T);
  localparam logic [TW-1:0] ZeroIv  = TW'(ZERO_T - PAUSE_T);
  localparam logic [TW-1:0] OneIv   = TW'(ONE_T - PAUSE_T);

  tx_state_e state_q, state_d;
  logic      coded_q, coded_d;
  logic      done_q, done_d;
  logic      kadv_q, kadv_d;

  always_comb begin
    state_d  = state_q;
    coded_d  = coded_q;
    done_d   = 1'b0;
    kadv_d   = 1'b0;
    load     = 1'b0;
    shift    = 1'b0;
    step     = 1'b0;
    interval = PauseIv;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          load    = 1'b1;
          state_d = ST_GAP;
        end
      end
      ST_GAP, ST_HOLD: begin
        if (hit) begin
          step = 1'b1;
          if (empty) begin
            state_d = ST_TAIL;
          end else begin
            state_d = ST_PAUSE;
            coded_d = cur_bit ^ key_bit;
            shift   = 1'b1;
            kadv_d  = 1'b1;
          end
        end
      end
      ST_PAUSE: begin
        if (hit) begin
          step     = 1'b1;
          interval = coded_q ? OneIv : ZeroIv;
          state_d  = ST_HOLD;
        end
      end
      ST_TAIL: begin
        if (hit) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      coded_q <= 1'b0;
      done_q  <= 1'b0;
      kadv_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      coded_q <= coded_d;
      done_q  <= done_d;
      kadv_q  <= kadv_d;
    end
  end

  assign carrier = !((state_q == ST_PAUSE) || (state_q == ST_TAIL));
  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;
  assign key_adv = kadv_q;

endmodule

// File: rtl/pp_frame_tx.sv
module pp_frame_tx
  import pp_tx_pkg::*;
#(
  parameter int unsigned MAX_BITS    = 32,
  parameter int unsigned GAP_TICKS   = 330,
  parameter int unsigned PAUSE_TICKS = 30,
  parameter int unsigned ZERO_TICKS  = 90,
  parameter int unsigned ONE_TICKS   = 150,
  localparam int unsigned LEN_W  = $clog2(MAX_BITS + 1),
  localparam int unsigned TIME_W =
    $clog2(worst_ticks(GAP_TICKS, MAX_BITS, ONE_TICKS, PAUSE_TICKS) + 2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                start,
  input  logic [MAX_BITS-1:0] frame_data,
  input  logic [LEN_W-1:0]    frame_len,
  input  logic                key_bit,
  output logic                carrier,
  output logic                key_adv,
  output logic                busy,
  output logic                done
);

  logic [1:0] rst_pipe_q;
  logic       rst_q_n;
  logic       load, shift, step, hit, cur_bit, empty;
  logic [TIME_W-1:0] interval;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_q_n = rst_pipe_q[1];

  pp_tx_sched #(.TW(TIME_W), .GAP(GAP_TICKS)) u_sched (
    .clk(clk), .rst_n(rst_q_n), .tick(tick), .load(load), .step(step),
    .interval(interval), .hit(hit)
  );

  pp_tx_shifter #(.MAXB(MAX_BITS), .LW(LEN_W)) u_shift (
    .clk(clk), .rst_n(rst_q_n), .load(load), .shift(shift),
    .frame_data(frame_data), .frame_len(frame_len),
    .cur_bit(cur_bit), .empty(empty)
  );

  pp_tx_ctrl #(.TW(TIME_W), .PAUSE_T(PAUSE_TICKS), .ZERO_T(ZERO_TICKS),
               .ONE_T(ONE_TICKS)) u_ctrl (
    .clk(clk), .rst_n(rst_q_n), .start(start), .hit(hit), .cur_bit(cur_bit),
    .key_bit(key_bit), .empty(empty), .load(load), .shift(shift), .step(step),
    .interval(interval), .carrier(carrier), .busy(busy), .done(done),
    .key_adv(key_adv)
  );

endmodule

// File: rtl/pp_frame_tx_chk.sv
module pp_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic start,
  input logic carrier,
  input logic key_adv,
  input logic busy,
  input logic done
);

  assert_idle_carrier_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> carrier);

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_keyadv_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    key_adv |=> !key_adv);

  assert_keyadv_in_pause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    key_adv |-> (busy && !carrier));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_finish_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done && carrier));

  assert_edge_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (carrier != $past(carrier)) |-> $past(tick));

endmodule

bind pp_frame_tx pp_frame_tx_chk u_chk (
  .clk(clk), .rst_n(rst_q_n), .tick(tick), .start(start), .carrier(carrier),
  .key_adv(key_adv), .busy(busy), .done(done)
);

// File: tb/pp_frame_tx_test.sv
module pp_frame_tx_test;

  localparam int CLK_PERIOD = 10;
  localparam int GAP = 330, PAUSE = 30, ZERO = 90, ONE = 150, MAXB = 32;

  logic        clk, rst_n, tick, start, key_bit;
  logic [31:0] frame_data;
  logic [5:0]  frame_len;
  logic        carrier, key_adv, busy, done;

  int checks = 0, fails = 0;

  // monitor state
  int tick_cnt = 0, base = 0, n_edges = 0, kadv_cnt = 0, done_cnt = 0, end_rel = 0;
  int edges [0:79];
  int div = 2, ph = 0, kidx = 0;
  logic [63:0] ks = '0;
  logic busy_prev = 1'b0, carr_prev = 1'b1, frame_over = 1'b0;

  pp_frame_tx uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
    .frame_data(frame_data), .frame_len(frame_len), .key_bit(key_bit),
    .carrier(carrier), .key_adv(key_adv), .busy(busy), .done(done)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor and timebase/keystream driver, all at the falling edge.
  initial begin
    tick = 1'b0;
    key_bit = 1'b0;
    forever begin
      @(negedge clk);
      if (tick) tick_cnt++;
      if (busy && !busy_prev) begin
        base = tick_cnt; n_edges = 0; kadv_cnt = 0; done_cnt = 0;
      end
      if ((busy || busy_prev) && carrier != carr_prev && n_edges < 80) begin
        edges[n_edges] = tick_cnt - base;
        n_edges++;
      end
      if (key_adv) begin kadv_cnt++; kidx++; end
      if (done) done_cnt++;
      if (!busy && busy_prev) begin end_rel = tick_cnt - base; frame_over = 1'b1; end
      busy_prev = busy;
      carr_prev = carrier;
      tick = (ph == 0);
      ph = (ph + 1) % div;
      key_bit = ks[kidx];
    end
  end

  task automatic send(input logic [31:0] d, input int len, input logic [63:0] k,
                      input int dv, input bit poke);
    int neff, t, e, tmo;
    bit c;
    div = dv;
    ks = k;
    kidx = 0;
    frame_over = 1'b0;
    @(negedge clk);
    frame_data = d;
    frame_len = 6'(len);
    start = 1'b1;
    @(negedge clk);
    check(busy === 1'b1, "R2 busy after start", busy, 1);
    start = 1'b0;
    if (poke) begin
      repeat (400) @(negedge clk);
      frame_data = ~d;
      frame_len = 6'd3;
      start = 1'b1;            // R2: must be ignored
      @(negedge clk);
      start = 1'b0;
    end
    tmo = 0;
    while (!frame_over && tmo < 40000) begin @(negedge clk); tmo++; end
    check(frame_over, "R6 frame finished", frame_over, 1);
    neff = (len > MAXB) ? MAXB : len;   // R8 clamp
    check(n_edges == 2 * neff + 2, "R4/R7/R8 edge count", n_edges, 2 * neff + 2);
    t = GAP;                            // R3 first pause after gap
    e = 0;
    for (int i = 0; i < neff; i++) begin
      c = d[i] ^ k[i];                  // R5 whitening
      if (e < n_edges) check(edges[e] == t, "R3/R4 pause start", edges[e], t);
      if (e + 1 < n_edges) check(edges[e + 1] == t + PAUSE, "R4 pause end", edges[e + 1], t + PAUSE);
      e += 2;
      t += c ? ONE : ZERO;
    end
    if (e < n_edges) check(edges[e] == t, "R6 end pause start", edges[e], t);
    if (e + 1 < n_edges) check(edges[e + 1] == t + PAUSE, "R6 end pause end", edges[e + 1], t + PAUSE);
    check(end_rel == t + PAUSE, "R6 busy falls at end", end_rel, t + PAUSE);
    check(done_cnt == 1, "R6 single done", done_cnt, 1);
    check(kadv_cnt == neff, "R5 key_adv per bit", kadv_cnt, neff);
    check(carrier === 1'b1, "R1 carrier idle high", carrier, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    rst_n = 1'b0;
    start = 1'b0;
    frame_data = '0;
    frame_len = '0;
    repeat (4) @(negedge clk);
    check(carrier === 1'b1 && busy === 1'b0 && done === 1'b0 && key_adv === 1'b0,
          "R1 reset state", {carrier, busy, done, key_adv}, 4'b1000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(carrier === 1'b1 && busy === 1'b0, "R1 idle after reset", {carrier, busy}, 2'b10);

    send(32'h0, 0, 64'h0, 2, 1'b0);                          // R7
    send(32'h1, 1, 64'h0, 1, 1'b0);                          // single one
    send(32'h1, 1, 64'h1, 3, 1'b0);                          // R5 key flips to zero
    send(32'hFFFF_FFFF, 32, 64'h0, 1, 1'b0);                 // all ones, R9 tick each clock
    send(32'hA5C3_0F96, 63, 64'h0123_4567_89AB_CDEF, 1, 1'b0); // R8 clamp
    send(32'h0000_00F0, 10, 64'h3C, 2, 1'b1);                // R2 ignored start
    for (int n = 0; n < 6; n++) begin
      send($urandom, int'($urandom_range(0, 32)), {$urandom, $urandom},
           int'($urandom_range(1, 3)), 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule